// File: doc/BRIEF.md
# Barrel-Scheduled I/O Processor

This block runs several independent I/O processor contexts on one shared execution slot. Each clock cycle the slot belongs to exactly one context. The owner rotates in a fixed order, so every context gets one instruction per turn. Each context has its own program counter, 18-bit accumulator and private word memory. No other context can read or write that memory.

The slot fetches a 12-bit word from the active context's memory and executes it in that same cycle. The supported instructions are:
- immediate load, memory load, add and store;
- a branch taken when the accumulator is zero;
- a central-memory read;
- a channel transfer in either direction.

Central-memory and channel requests are single-cycle pulses tagged with the issuing context. Responses come back later on the matching port with the same tag.

A context waiting for a response keeps its place in the rotation, but its turns pass as empty bubbles. A side port fills the private memories while reset is held. At the default build each memory holds 64 words; setting the address width to 12 gives 4096 words.

Top module: `barrel_iop`

## Requirements
- R1: The shared slot serves context 0, 1, …, NUM_CTX-1 and then 0 again, one context per cycle, with no gaps. Rotation restarts at context 0 after reset. NUM_CTX may be 10, 14 or 20, among other values. The active context appears on `slotCtx`.
- R2: After reset every context starts at address 0 with a zero accumulator.
- R3: An instruction word holds an opcode in bits 11:9 and an argument in bits 8:0. The opcodes are:
  - 0 no-op;
  - 1 load the zero-extended argument into the accumulator;
  - 2 load the zero-extended local word at the argument address;
  - 3 add;
  - 4 store;
  - 5 branch;
  - 6 central read;
  - 7 channel.

  Local addresses are the argument cut or zero-extended to the address width.
- R4: Opcode 3 adds the zero-extended local word at the argument address to the accumulator, modulo 2^18.
- R5: Opcode 4 writes the low 12 accumulator bits to the argument address in the active context's own memory. The same address in any other context is left unchanged.
- R6: Opcode 5 jumps to the argument address when the accumulator is zero; otherwise execution goes to the next address. The executed address appears on `retPc` whenever `retire` is high.
- R7: Without a jump, the program counter advances by one and wraps from the last address to 0.
- R8: Opcode 6 pulses `cmReq` for one cycle, with the accumulator on `cmAddr` and the context on `cmCtx`. A later `cmRspValid` carrying that context's tag loads `cmRspData` into the accumulator. Only one request of either kind is raised per cycle.
- R9: Opcode 7 pulses `chReq`, with channel number = argument bits 7:0 on `chSel`. When argument bit 8 is 0 the transfer is an output: `chOut` is high, `chWdata` carries the accumulator, and the acknowledgement leaves the accumulator unchanged. When bit 8 is 1 the transfer is an input: `chOut` is low and the acknowledgement's `chRspData` is loaded into the accumulator.
- R10: After issuing a request, a context's turns keep coming with `retire` low until the matching response arrives. Execution then resumes at the following address.
- R11: A response is ignored if its tag names:
  - a context with no request outstanding on that port;
  - a context whose request went out in the same cycle;
  - a value of NUM_CTX or above.
- R12: While `imgWe` is high, `imgData` is written to address `imgAddr` of the memory of context `imgCtx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imgWe | input | 1 | Image write strobe |
| imgCtx | input | CTX_W | Context whose memory is written |
| imgAddr | input | ADDR_W | Image write address |
| imgData | input | 12 | Image write word |
| slotCtx | output | CTX_W | Context owning the slot this cycle |
| retire | output | 1 | Active context executes an instruction this cycle |
| retPc | output | ADDR_W | Address of the executed instruction |
| cmReq | output | 1 | Central-memory read request pulse |
| cmAddr | output | 18 | Central-memory address |
| cmCtx | output | CTX_W | Tag of the requesting context |
| cmRspValid | input | 1 | Central-memory response strobe |
| cmRspCtx | input | CTX_W | Tag of the response |
| cmRspData | input | 18 | Central-memory read data |
| chReq | output | 1 | Channel request pulse |
| chOut | output | 1 | 1 = output transfer, 0 = input transfer |
| chSel | output | 8 | Channel number |
| chWdata | output | 18 | Output data |
| chCtx | output | CTX_W | Tag of the requesting context |
| chRspValid | input | 1 | Channel acknowledgement strobe |
| chRspCtx | input | CTX_W | Tag of the acknowledgement |
| chRspData | input | 18 | Input data |

## Verification
The hardest situation to reach is a response that arrives while several contexts are stalled at once. The response may hit the right context, the wrong port, a context that is not waiting, or a tag beyond the last context. Any misrouted response only shows up many turns later as a wrong accumulator value.

The stimulus therefore keeps a reference model of every context. It answers outstanding requests after random delays and sprays stray responses into the idle slots of both ports. It compares every output on every cycle. A directed program run first forces a store collision between contexts, an 18-bit add overflow, a taken and an untaken branch, and a program-counter wrap. Each result is read back through channel output transfers.

// File: rtl/barrel_iop_pkg.sv
package barrel_iop_pkg;
  localparam int WORD_W  = 12;
  localparam int ACC_W   = 18;
  localparam int OP_W    = 3;
  localparam int ARG_W   = 9;
  localparam int CHSEL_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_LDI = 3'd1,
    OP_LDM = 3'd2,
    OP_ADD = 3'd3,
    OP_STM = 3'd4,
    OP_BZ  = 3'd5,
    OP_CRD = 3'd6,
    OP_CHN = 3'd7
  } op_e;

  // strobes from the sequencer to the datapath for the active context
  typedef struct packed {
    logic exec;
    logic ldImm;
    logic ldMem;
    logic addMem;
    logic stMem;
    logic jump;
    logic cmIssue;
    logic chIssue;
  } strobe_t;
endpackage

// File: rtl/barrel_iop_ctrl.sv
module barrel_iop_ctrl
  import barrel_iop_pkg::*;
#(
  parameter int NUM_CTX = 10,
  localparam int CTX_W = $clog2(NUM_CTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opField,
  input  logic             dirIn,
  input  logic             accZero,
  input  logic             cmRspValid,
  input  logic [CTX_W-1:0] cmRspCtx,
  input  logic             chRspValid,
  input  logic [CTX_W-1:0] chRspCtx,
  output logic [CTX_W-1:0] slot,
  output strobe_t          strb,
  output logic             cmLoad,
  output logic             chLoad
);
  logic [CTX_W-1:0]   slotQ;
  logic [NUM_CTX-1:0] pendQ;
  logic [NUM_CTX-1:0] viaChQ;
  logic [NUM_CTX-1:0] loadQ;
  op_e  op;
  logic busy;
  logic lastSlot;
  logic cmHit;
  logic chHit;
  logic cmInRange;
  logic chInRange;

  assign op       = op_e'(opField);
  assign slot     = slotQ;
  assign busy     = pendQ[slotQ];
  assign lastSlot = (int'(slotQ) == NUM_CTX - 1);

  always_ff @(posedge clk) begin
    if (rst)           slotQ <= '0;
    else if (lastSlot) slotQ <= '0;
    else               slotQ <= slotQ + 1'b1;
  end

  always_comb begin
    strb      = '0;
    strb.exec = !busy;
    if (!busy) begin
      unique case (op)
        OP_LDI:  strb.ldImm   = 1'b1;
        OP_LDM:  strb.ldMem   = 1'b1;
        OP_ADD:  strb.addMem  = 1'b1;
        OP_STM:  strb.stMem   = 1'b1;
        OP_BZ:   strb.jump    = accZero;
        OP_CRD:  strb.cmIssue = 1'b1;
        OP_CHN:  strb.chIssue = 1'b1;
        default: ;
      endcase
    end
  end

  assign cmInRange = int'(cmRspCtx) < NUM_CTX;
  assign chInRange = int'(chRspCtx) < NUM_CTX;
  assign cmHit  = cmRspValid && cmInRange && pendQ[cmRspCtx] && !viaChQ[cmRspCtx];
  assign chHit  = chRspValid && chInRange && pendQ[chRspCtx] && viaChQ[chRspCtx];
  assign cmLoad = cmHit;
  assign chLoad = chHit && loadQ[chRspCtx];

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ  <= '0;
      viaChQ <= '0;
      loadQ  <= '0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if ((strb.cmIssue || strb.chIssue) && int'(slotQ) == c) begin
          pendQ[c]  <= 1'b1;
          viaChQ[c] <= strb.chIssue;
          loadQ[c]  <= strb.cmIssue || dirIn;
        end else if ((cmHit && int'(cmRspCtx) == c) || (chHit && int'(chRspCtx) == c)) begin
          pendQ[c]  <= 1'b0;
        end
      end
    end
  end

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    lastSlot |=> slotQ == '0);

  // R10
  issue_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.cmIssue || strb.chIssue) |=> pendQ[$past(slotQ)]);

  // R11
  stray_cm_chk: assert property (@(posedge clk) disable iff (rst)
    (cmRspValid && cmInRange && !strb.cmIssue && !strb.chIssue && !pendQ[cmRspCtx])
      |=> !pendQ[$past(cmRspCtx)]);
endmodule

// File: rtl/barrel_iop_dp.sv
module barrel_iop_dp
  import barrel_iop_pkg::*;
#(
  parameter int NUM_CTX = 10,
  parameter int ADDR_W  = 6,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTX_W-1:0]  slot,
  input  strobe_t           strb,
  input  logic              cmLoad,
  input  logic [CTX_W-1:0]  cmRspCtx,
  input  logic [ACC_W-1:0]  cmRspData,
  input  logic              chLoad,
  input  logic [CTX_W-1:0]  chRspCtx,
  input  logic [ACC_W-1:0]  chRspData,
  input  logic              imgWe,
  input  logic [CTX_W-1:0]  imgCtx,
  input  logic [ADDR_W-1:0] imgAddr,
  input  logic [WORD_W-1:0] imgData,
  output logic [WORD_W-1:0] instr,
  output logic [ADDR_W-1:0] curPc,
  output logic [ACC_W-1:0]  curAcc,
  output logic              accZero
);
  logic [WORD_W-1:0] memQ [NUM_CTX][DEPTH];
  logic [ADDR_W-1:0] pcQ  [NUM_CTX];
  logic [ACC_W-1:0]  accQ [NUM_CTX];

  logic [ADDR_W-1:0] argAddr;
  logic [WORD_W-1:0] operand;
  logic [ACC_W-1:0]  opExt;
  logic [ACC_W-1:0]  accNew;
  logic [ADDR_W-1:0] pcNew;
  logic              accWr;

  assign curPc   = pcQ[slot];
  assign curAcc  = accQ[slot];
  assign instr   = memQ[slot][curPc];
  assign argAddr = ADDR_W'(instr[ARG_W-1:0]);
  assign operand = memQ[slot][argAddr];
  assign opExt   = ACC_W'(operand);
  assign accZero = (curAcc == '0);
  assign accWr   = strb.ldImm || strb.ldMem || strb.addMem;
  assign pcNew   = strb.jump ? argAddr : curPc + 1'b1;

  always_comb begin
    if (strb.ldImm)      accNew = ACC_W'(instr[ARG_W-1:0]);
    else if (strb.ldMem) accNew = opExt;
    else                 accNew = curAcc + opExt;
  end

  // private memories: image port has precedence over a store
  always_ff @(posedge clk) begin
    if (imgWe && int'(imgCtx) < NUM_CTX) memQ[imgCtx][imgAddr] <= imgData;
    else if (strb.stMem)                 memQ[slot][argAddr]   <= curAcc[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CTX; c++) begin
        pcQ[c]  <= '0;
        accQ[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (strb.exec && int'(slot) == c) pcQ[c] <= pcNew;
        if (accWr && int'(slot) == c)             accQ[c] <= accNew;
        else if (cmLoad && int'(cmRspCtx) == c)   accQ[c] <= cmRspData;
        else if (chLoad && int'(chRspCtx) == c)   accQ[c] <= chRspData;
      end
    end
  end

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.exec && !strb.jump) |=> pcQ[$past(slot)] == ADDR_W'($past(curPc) + 1'b1));
endmodule

// File: rtl/barrel_iop.sv
module barrel_iop
  import barrel_iop_pkg::*;
#(
  parameter int NUM_CTX = 10,
  parameter int ADDR_W  = 6,
  localparam int CTX_W  = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imgWe,
  input  logic [CTX_W-1:0]   imgCtx,
  input  logic [ADDR_W-1:0]  imgAddr,
  input  logic [WORD_W-1:0]  imgData,
  output logic [CTX_W-1:0]   slotCtx,
  output logic               retire,
  output logic [ADDR_W-1:0]  retPc,
  output logic               cmReq,
  output logic [ACC_W-1:0]   cmAddr,
  output logic [CTX_W-1:0]   cmCtx,
  input  logic               cmRspValid,
  input  logic [CTX_W-1:0]   cmRspCtx,
  input  logic [ACC_W-1:0]   cmRspData,
  output logic               chReq,
  output logic               chOut,
  output logic [CHSEL_W-1:0] chSel,
  output logic [ACC_W-1:0]   chWdata,
  output logic [CTX_W-1:0]   chCtx,
  input  logic               chRspValid,
  input  logic [CTX_W-1:0]   chRspCtx,
  input  logic [ACC_W-1:0]   chRspData
);
  logic [CTX_W-1:0]  slot;
  strobe_t           strb;
  logic              cmLoad;
  logic              chLoad;
  logic [WORD_W-1:0] instr;
  logic [ADDR_W-1:0] curPc;
  logic [ACC_W-1:0]  curAcc;
  logic              accZero;

  barrel_iop_ctrl #(.NUM_CTX(NUM_CTX)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opField    (instr[WORD_W-1:ARG_W]),
    .dirIn      (instr[ARG_W-1]),
    .accZero    (accZero),
    .cmRspValid (cmRspValid),
    .cmRspCtx   (cmRspCtx),
    .chRspValid (chRspValid),
    .chRspCtx   (chRspCtx),
    .slot       (slot),
    .strb       (strb),
    .cmLoad     (cmLoad),
    .chLoad     (chLoad)
  );

  barrel_iop_dp #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .slot      (slot),
    .strb      (strb),
    .cmLoad    (cmLoad),
    .cmRspCtx  (cmRspCtx),
    .cmRspData (cmRspData),
    .chLoad    (chLoad),
    .chRspCtx  (chRspCtx),
    .chRspData (chRspData),
    .imgWe     (imgWe),
    .imgCtx    (imgCtx),
    .imgAddr   (imgAddr),
    .imgData   (imgData),
    .instr     (instr),
    .curPc     (curPc),
    .curAcc    (curAcc),
    .accZero   (accZero)
  );

  assign slotCtx = slot;
  assign retire  = strb.exec;
  assign retPc   = curPc;
  assign cmReq   = strb.cmIssue;
  assign cmAddr  = curAcc;
  assign cmCtx   = slot;
  assign chReq   = strb.chIssue;
  assign chOut   = !instr[ARG_W-1];
  assign chSel   = instr[CHSEL_W-1:0];
  assign chWdata = curAcc;
  assign chCtx   = slot;

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmReq, chReq}));
endmodule

// File: tb/test_barrel_iop.sv
module test_barrel_iop;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imgWe = 1'b0;
  logic [CW-1:0] imgCtx = '0;
  logic [AW-1:0] imgAddr = '0;
  logic [11:0]   imgData = '0;
  logic [CW-1:0] slotCtx;
  logic          retire;
  logic [AW-1:0] retPc;
  logic          cmReq;
  logic [17:0]   cmAddr;
  logic [CW-1:0] cmCtx;
  logic          cmRspValid = 1'b0;
  logic [CW-1:0] cmRspCtx = '0;
  logic [17:0]   cmRspData = '0;
  logic          chReq;
  logic          chOut;
  logic [7:0]    chSel;
  logic [17:0]   chWdata;
  logic [CW-1:0] chCtx;
  logic          chRspValid = 1'b0;
  logic [CW-1:0] chRspCtx = '0;
  logic [17:0]   chRspData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_iop #(.NUM_CTX(N), .ADDR_W(AW)) i_barrel_iop (.*);

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [11:0] mMem [N][DEPTH];
  logic [AW-1:0] mPc [N];
  logic [17:0] mAcc [N];
  bit mPend [N];
  bit mKind [N];   // 1 = channel
  bit mLoad [N];
  int mDly  [N];
  int mSlot;
  logic [17:0] outVal [N][8];
  int outCnt [N];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] enc(int op, int arg);
    return {3'(op), 9'(arg)};
  endfunction

  task automatic modelReset();
    for (int c = 0; c < N; c++) begin
      mPc[c] = '0; mAcc[c] = '0; mPend[c] = 0; mKind[c] = 0;
      mLoad[c] = 0; mDly[c] = 0; outCnt[c] = 0;
    end
    mSlot = 0;
  endtask

  // R12: images go in through the image port while reset is held
  task automatic loadAndReset();
    rst = 1'b1;
    cmRspValid = 1'b0;
    chRspValid = 1'b0;
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      for (int a = 0; a < DEPTH; a++) begin
        imgWe = 1'b1; imgCtx = CW'(c); imgAddr = AW'(a); imgData = mMem[c][a];
        @(negedge clk);
      end
    end
    imgWe = 1'b0;
    @(negedge clk);
    modelReset();
    rst = 1'b0;
  endtask

  task automatic checkCycle();
    int c = mSlot;
    bit busy = mPend[c];
    logic [11:0] w = mMem[c][mPc[c]];
    int op = int'(w[11:9]);
    bit expCm = !busy && op == 6;
    bit expCh = !busy && op == 7;
    chk(int'(slotCtx) == c, "R1 slot owner", 32'(slotCtx), 32'(c));
    chk(retire == !busy, "R10 retire", 32'(retire), 32'(!busy));
    if (!busy) chk(retPc == mPc[c], "R6 executed address", 32'(retPc), 32'(mPc[c]));
    chk(cmReq == expCm, "R8 cmReq", 32'(cmReq), 32'(expCm));
    if (expCm) begin
      chk(cmAddr == mAcc[c], "R8 cmAddr", 32'(cmAddr), 32'(mAcc[c]));
      chk(int'(cmCtx) == c, "R8 cmCtx", 32'(cmCtx), 32'(c));
    end
    chk(chReq == expCh, "R9 chReq", 32'(chReq), 32'(expCh));
    if (expCh) begin
      chk(chOut == !w[8], "R9 chOut", 32'(chOut), 32'(!w[8]));
      chk(chSel == w[7:0], "R9 chSel", 32'(chSel), 32'(w[7:0]));
      chk(int'(chCtx) == c, "R9 chCtx", 32'(chCtx), 32'(c));
      if (!w[8]) begin
        chk(chWdata == mAcc[c], "R9 chWdata", 32'(chWdata), 32'(mAcc[c]));
        if (outCnt[c] < 8) begin
          outVal[c][outCnt[c]] = chWdata;
          outCnt[c]++;
        end
      end
    end
  endtask

  // drive responses for the coming edge and advance the model across it
  task automatic stepModel(bit directed);
    int c = mSlot;
    bit busy = mPend[c];
    int cmSv = -1;
    int chSv = -1;
    logic [17:0] cmD;
    logic [17:0] chD;
    for (int i = 0; i < N; i++) begin
      if (cmSv < 0 && mPend[i] && !mKind[i] && mDly[i] == 0) cmSv = i;
      if (chSv < 0 && mPend[i] &&  mKind[i] && mDly[i] == 0) chSv = i;
    end
    cmD = directed ? 18'(32'h3FFF0 + cmSv) : 18'($urandom);
    chD = directed ? 18'(32'h12340 + chSv) : 18'($urandom);
    cmRspValid = 1'b0;
    chRspValid = 1'b0;
    if (cmSv >= 0) begin
      cmRspValid = 1'b1; cmRspCtx = CW'(cmSv); cmRspData = cmD;
    end else if ($urandom % 3 == 0) begin
      int r = int'($urandom % 16);
      // R11: stray tag, idle context, wrong port or out of range
      if (!(r < N && mPend[r] && !mKind[r])) begin
        cmRspValid = 1'b1; cmRspCtx = CW'(r); cmRspData = 18'($urandom);
      end
    end
    if (chSv >= 0) begin
      chRspValid = 1'b1; chRspCtx = CW'(chSv); chRspData = chD;
    end else if ($urandom % 3 == 0) begin
      int r = int'($urandom % 16);
      if (!(r < N && mPend[r] && mKind[r])) begin
        chRspValid = 1'b1; chRspCtx = CW'(r); chRspData = 18'($urandom);
      end
    end
    if (cmSv >= 0) begin
      mAcc[cmSv] = cmD; mPend[cmSv] = 0;
    end
    if (chSv >= 0) begin
      if (mLoad[chSv]) mAcc[chSv] = chD;
      mPend[chSv] = 0;
    end
    for (int i = 0; i < N; i++)
      if (mPend[i] && mDly[i] > 0) mDly[i]--;
    if (!busy) begin
      logic [11:0] w = mMem[c][mPc[c]];
      int op = int'(w[11:9]);
      logic [AW-1:0] a = AW'(w[8:0]);
      logic [AW-1:0] nx = mPc[c] + 1'b1;
      case (op)
        1: mAcc[c] = 18'(w[8:0]);
        2: mAcc[c] = 18'(mMem[c][a]);
        3: mAcc[c] = mAcc[c] + 18'(mMem[c][a]);
        4: mMem[c][a] = mAcc[c][11:0];
        5: if (mAcc[c] == 0) nx = a;
        6: begin mPend[c] = 1; mKind[c] = 0; mLoad[c] = 1; mDly[c] = int'($urandom % 4); end
        7: begin mPend[c] = 1; mKind[c] = 1; mLoad[c] = w[8]; mDly[c] = int'($urandom % 4); end
        default: ;
      endcase
      mPc[c] = nx;
    end
    mSlot = (mSlot + 1) % N;
  endtask

  task automatic runCycles(int n, bit directed);
    for (int k = 0; k < n; k++) begin
      checkCycle();
      stepModel(directed);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // directed programs, identical code, per-context data
    for (int c = 0; c < N; c++) begin
      for (int a = 0; a < DEPTH; a++) mMem[c][a] = enc(0, 0);
      mMem[c][0]  = enc(7, 1);
      mMem[c][1]  = enc(1, 'h155);
      mMem[c][2]  = enc(7, 2);
      mMem[c][3]  = enc(2, 40);
      mMem[c][4]  = enc(3, 41);
      mMem[c][5]  = enc(4, 42);
      mMem[c][6]  = enc(2, 42);
      mMem[c][7]  = enc(7, 4);
      mMem[c][8]  = enc(6, 0);
      mMem[c][9]  = enc(3, 41);
      mMem[c][10] = enc(7, 5);
      mMem[c][11] = enc(7, 'h103);
      mMem[c][12] = enc(7, 6);
      mMem[c][13] = enc(5, 20);
      mMem[c][14] = enc(1, 0);
      mMem[c][15] = enc(5, 20);
      mMem[c][16] = enc(1, 'h0AA);
      mMem[c][20] = enc(7, 7);
      mMem[c][21] = enc(5, 50);
      mMem[c][40] = 12'(c * 16 + 7);
      mMem[c][41] = 12'hFFF;
      mMem[c][62] = enc(1, 'h077);
    end
    loadAndReset();
    // R2: reset state visible before the first working edge
    chk(slotCtx == '0, "R2 first slot", 32'(slotCtx), 0);
    chk(retPc == '0, "R2 start address", 32'(retPc), 0);
    runCycles(2000, 1'b1);
    for (int c = 0; c < N; c++) begin
      chk(outCnt[c] >= 7, "R9 output count", 32'(outCnt[c]), 7);
      chk(outVal[c][0] == 18'h0, "R2 zero accumulator", 32'(outVal[c][0]), 0);
      chk(outVal[c][1] == 18'h155, "R3 immediate load", 32'(outVal[c][1]), 32'h155);
      // R5 and R12: same address stored by every context, each reads its own
      chk(outVal[c][2] == 18'(c * 16 + 6), "R5 private store", 32'(outVal[c][2]), 32'(c * 16 + 6));
      chk(outVal[c][3] == 18'(32'hFEF + c), "R4 add wrap", 32'(outVal[c][3]), 32'(32'hFEF + c));
      chk(outVal[c][4] == 18'(32'h12340 + c), "R9 channel input", 32'(outVal[c][4]), 32'(32'h12340 + c));
      chk(outVal[c][5] == 18'h0, "R6 branch taken", 32'(outVal[c][5]), 0);
      chk(outVal[c][6] == 18'h77, "R7 address wrap", 32'(outVal[c][6]), 32'h77);
    end
    // random programs and data, R11 strays throughout
    for (int c = 0; c < N; c++)
      for (int a = 0; a < DEPTH; a++) mMem[c][a] = 12'($urandom);
    loadAndReset();
    runCycles(20000, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule